// File: doc/BRIEF.md
# Multi-block DMA channel sequencer

This block sequences one DMA channel through a transfer made of one or more blocks. Software loads the source address, destination address, next-descriptor pointer, control and configuration registers through a small register write port, then pulses `start`. The first block always uses the programmed values. The actual data movement is done elsewhere: the sequencer presents the block's addresses and byte length with `blk_busy` high and waits for a `blk_done` pulse.

At every block boundary the sequencer works out the next block's addresses one side at a time. A side is either restored from a copy taken at enable time (reload), continued directly after the previous block (contiguous), or loaded from a descriptor fetched from memory (linked). A linked fetch reads five words through a one-word-at-a-time read port. Those words also replace the control word and the pointer.

A block where neither side links or reloads is the final block of the transfer. Any other change of mode between blocks is an error and stops the channel. A link and a reload on the same side are rejected when `start` is pulsed. Five status sources, each with a raw bit, a mask bit and write-one-to-clear, report what happened.

Top module: `dma_chain_seq`

## Requirements
- R1: While `rst_n` is low, `chan_en`, `blk_busy`, `rd_req`, `irq`, `raw_stat` and `irq_stat` are all zero.
- R2: If the pointer is 0 and the control bits [1:0] and configuration bits [1:0] are all 0 when `start` is pulsed, exactly one block runs with the programmed source, destination and length. Then `raw_stat` bit 0 (transfer) and bit 1 (block) are set, and `chan_en` falls in the same cycle that bit 0 rises.
- R3: A side whose reload bit is set (configuration bit 0 for source, bit 1 for destination) starts every later block at the address it held when `start` was accepted. The transfer keeps repeating until both reload bits are read as 0 at a block boundary. One further block then runs and the transfer completes.
- R4: A side that neither reloads nor links starts the next block at the previous start address plus the byte length. The byte length is held in control-high bits [LEN_W-1:0].
- R5: A side links when control bit 1 (source) or bit 0 (destination) is set. When the finished block has a linked side, five words are read from the pointer with its two low bits forced to 0, at rising word addresses. The words, in order, are source, destination, pointer, control-low and control-high. Linked sides take the fetched addresses, and the control word and pointer are replaced. Only one read is outstanding at a time, and its address is held until `rd_ack`.
- R6: A block in which neither side links nor reloads is the final block, whether the pointer is zero or not.
- R7: A `start` pulse with link and reload set on the same side sets `raw_stat` bit 4 (error), leaves `chan_en` low and runs no block.
- R8: At a boundary, the next block's mode must equal the previous block's mode or be all-contiguous. Otherwise bit 4 is set, the channel disables, no further block runs and bit 0 stays clear.
- R9: Bit 1 is set for every completed block, including the last. Bit 0 is set once, when the transfer finishes.
- R10: A write to select 7 clears each `raw_stat` bit whose data bit is 1. A write to select 6 loads the mask. `irq_stat` equals `raw_stat` AND mask, and `irq` is the OR of `irq_stat`.
- R11: `src_xact` and `dst_xact` pulses set bits 2 and 3 only while `chan_en` is high.
- R12: While `chan_en` is high, `start` and writes to selects 0 to 4 have no effect. Configuration writes (select 5) are accepted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 source, 1 destination, 2 pointer, 3 control-low, 4 control-high, 5 configuration, 6 mask, 7 status clear |
| reg_wdata | input | DW | Register write data |
| start | input | 1 | Enable pulse for the channel |
| chan_en | output | 1 | Channel enabled (busy) |
| blk_busy | output | 1 | A block is handed to the data mover |
| blk_src | output | DW | Source address of the current block |
| blk_dst | output | DW | Destination address of the current block |
| blk_len | output | LEN_W | Byte length of the current block |
| blk_done | input | 1 | Data mover finished the current block |
| src_xact | input | 1 | Source transaction completed pulse |
| dst_xact | input | 1 | Destination transaction completed pulse |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | DW | Descriptor word byte address |
| rd_ack | input | 1 | Read data valid, request accepted |
| rd_data | input | DW | Descriptor word |
| raw_stat | output | 5 | Raw status: 0 transfer, 1 block, 2 source xact, 3 destination xact, 4 error |
| irq_stat | output | 5 | Masked status |
| irq | output | 1 | Any masked status set |

## Verification
The sequencer is driven with these programmings:
- a lone block, which checks the terminal single-block path;
- reload on both sides, cleared during the third block, which separates "finish after next block" from "finish now";
- contiguous source with reloaded destination, which shows that each side takes its own update;
- a two-descriptor chain ending on a non-zero pointer, and another ending on a zero pointer, which check the fetch word order and both terminal routes;
- a source-only link whose descriptor switches both links on, which must raise an error rather than continue.

An illegal same-side combination at start, a write to the source register mid-transfer, a repeated `start` and transaction pulses both while idle and while enabled confirm the cases that must have no effect.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // per-side address update method
  typedef enum logic [1:0] {
    UPD_CONT   = 2'd0,
    UPD_RELOAD = 2'd1,
    UPD_LINK   = 2'd2
  } upd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FETCH = 2'd2,
    ST_CHECK = 2'd3
  } st_e;

  // status bit positions
  localparam int NSTAT     = 5;
  localparam int STAT_TFR  = 0;
  localparam int STAT_BLK  = 1;
  localparam int STAT_SRCT = 2;
  localparam int STAT_DSTT = 3;
  localparam int STAT_ERR  = 4;

  // descriptor layout (word order in memory)
  localparam int DESC_WORDS = 5;
  localparam int DW_SRC     = 0;
  localparam int DW_DST     = 1;
  localparam int DW_PTR     = 2;
  localparam int DW_CLO     = 3;
  localparam int DW_CHI     = 4;

  // register selects
  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_PTR  = 3'd2;
  localparam logic [2:0] SEL_CLO  = 3'd3;
  localparam logic [2:0] SEL_CHI  = 3'd4;
  localparam logic [2:0] SEL_CFG  = 3'd5;
  localparam logic [2:0] SEL_MASK = 3'd6;
  localparam logic [2:0] SEL_CLR  = 3'd7;

endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
  import dma_seq_pkg::*;
(
  input  logic [1:0] link_en,    // [1] source, [0] destination
  input  logic [1:0] reload_en,  // [0] source, [1] destination
  output upd_e       meth [2],   // [0] source, [1] destination
  output logic       illegal
);

  logic [1:0] bad;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic lk;
    assign lk      = link_en[1-s];
    assign meth[s] = lk ? UPD_LINK : (reload_en[s] ? UPD_RELOAD : UPD_CONT);
    assign bad[s]  = lk & reload_en[s];
  end

  assign illegal = |bad;

endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_seq_pkg::*;
#(
  parameter int DW = 32,
  parameter int NW = DESC_WORDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] base,
  output logic          rd_req,
  output logic [DW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic [DW-1:0] words [NW]
);

  localparam int IW = $clog2(NW);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] base_q, base_d;
  logic          cap_en;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    base_d = base_q;
    done_d = 1'b0;
    cap_en = 1'b0;
    if (go) begin
      busy_d = 1'b1;
      idx_d  = '0;
      base_d = {base[DW-1:2], 2'b00};
    end else if (busy_q && rd_ack) begin
      cap_en = 1'b1;
      if (idx_q == IW'(NW-1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      base_q <= base_d;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           word_q <= '0;
      else if (cap_en && idx_q == IW'(w))   word_q <= rd_data;
    end
    assign words[w] = word_q;
  end

  assign rd_req  = busy_q;
  assign rd_addr = base_q + {{(DW-IW-2){1'b0}}, idx_q, 2'b00};
  assign done    = done_q;

endmodule

// File: rtl/dma_stat_bank.sv
module dma_stat_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         irq
);

  logic [N-1:0] mask_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic raw_q, raw_d;
    always_comb begin
      raw_d = raw_q;
      if (clr_we && wbits[i]) raw_d = 1'b0;
      if (set[i])             raw_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= 1'b0;
      else        raw_q <= raw_d;
    end
    assign raw[i] = raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wbits;
  end

  assign masked = raw & mask_q;
  assign irq    = |masked;

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_seq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             start,
  output logic             chan_en,
  output logic             blk_busy,
  output logic [DW-1:0]    blk_src,
  output logic [DW-1:0]    blk_dst,
  output logic [LEN_W-1:0] blk_len,
  input  logic             blk_done,
  input  logic             src_xact,
  input  logic             dst_xact,
  output logic             rd_req,
  output logic [DW-1:0]    rd_addr,
  input  logic             rd_ack,
  input  logic [DW-1:0]    rd_data,
  output logic [NSTAT-1:0] raw_stat,
  output logic [NSTAT-1:0] irq_stat,
  output logic             irq
);

  st_e              st_q, st_d;
  logic [DW-1:0]    addr_q [2];
  logic [DW-1:0]    addr_d [2];
  logic [DW-1:0]    shadow_q [2];
  logic [DW-1:0]    shadow_d [2];
  upd_e             meth_q [2];
  upd_e             meth_d [2];
  logic [DW-1:0]    ptr_q, ptr_d;
  logic [1:0]       link_q, link_d;
  logic [1:0]       rel_q, rel_d;
  logic [LEN_W-1:0] len_q, len_d;

  upd_e             live_meth [2];
  logic             live_bad;
  logic [DW-1:0]    bnd_addr [2];
  logic [DW-1:0]    len_ext;
  logic [DW-1:0]    desc_w [DESC_WORDS];
  logic             fetch_done;
  logic             unused_desc;

  logic idle, term_cur, link_cur, live_term, live_same;
  logic start_ok, start_bad, blk_end, fin, chk_bad, fetch_go;
  logic [NSTAT-1:0] stat_set;

  dma_mode_decode u_dec (
    .link_en   (link_q),
    .reload_en (rel_q),
    .meth      (live_meth),
    .illegal   (live_bad)
  );

  dma_desc_fetch #(.DW(DW), .NW(DESC_WORDS)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (fetch_go),
    .base    (ptr_q),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .rd_data (rd_data),
    .done    (fetch_done),
    .words   (desc_w)
  );

  assign len_ext = {{(DW-LEN_W){1'b0}}, len_q};

  // boundary address per side: restore from shadow or continue after block
  for (genvar s = 0; s < 2; s++) begin : g_bnd
    assign bnd_addr[s] = (meth_q[s] == UPD_RELOAD) ? shadow_q[s]
                                                   : addr_q[s] + len_ext;
  end

  assign idle      = (st_q == ST_IDLE);
  assign term_cur  = (meth_q[0] == UPD_CONT) && (meth_q[1] == UPD_CONT);
  assign link_cur  = (meth_q[0] == UPD_LINK) || (meth_q[1] == UPD_LINK);
  assign live_term = (live_meth[0] == UPD_CONT) && (live_meth[1] == UPD_CONT);
  assign live_same = (live_meth[0] == meth_q[0]) && (live_meth[1] == meth_q[1]);

  assign start_ok  = start && idle && !live_bad;
  assign start_bad = start && idle && live_bad;
  assign blk_end   = (st_q == ST_RUN) && blk_done;
  assign fin       = blk_end && term_cur;
  assign fetch_go  = blk_end && !term_cur && link_cur;
  assign chk_bad   = (st_q == ST_CHECK) && (live_bad || (!live_term && !live_same));

  // next-state logic
  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    shadow_d = shadow_q;
    meth_d   = meth_q;
    ptr_d    = ptr_q;
    link_d   = link_q;
    rel_d    = rel_q;
    len_d    = len_q;

    if (reg_we && reg_sel == SEL_CFG) rel_d = reg_wdata[1:0];
    if (reg_we && idle) begin
      unique case (reg_sel)
        SEL_SRC: addr_d[0] = reg_wdata;
        SEL_DST: addr_d[1] = reg_wdata;
        SEL_PTR: ptr_d     = reg_wdata;
        SEL_CLO: link_d    = reg_wdata[1:0];
        SEL_CHI: len_d     = reg_wdata[LEN_W-1:0];
        default: ;
      endcase
    end

    unique case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          shadow_d = addr_q;
          meth_d   = live_meth;
          st_d     = ST_RUN;
        end
      end
      ST_RUN: begin
        if (blk_done) begin
          if (term_cur) begin
            st_d = ST_IDLE;
          end else begin
            for (int s = 0; s < 2; s++)
              if (meth_q[s] != UPD_LINK) addr_d[s] = bnd_addr[s];
            st_d = link_cur ? ST_FETCH : ST_CHECK;
          end
        end
      end
      ST_FETCH: begin
        if (fetch_done) begin
          if (meth_q[0] == UPD_LINK) addr_d[0] = desc_w[DW_SRC];
          if (meth_q[1] == UPD_LINK) addr_d[1] = desc_w[DW_DST];
          ptr_d  = desc_w[DW_PTR];
          link_d = desc_w[DW_CLO][1:0];
          len_d  = desc_w[DW_CHI][LEN_W-1:0];
          st_d   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (chk_bad) begin
          st_d = ST_IDLE;
        end else begin
          meth_d = live_meth;
          st_d   = ST_RUN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      link_q <= '0;
      rel_q  <= '0;
      len_q  <= '0;
      for (int s = 0; s < 2; s++) begin
        addr_q[s]   <= '0;
        shadow_q[s] <= '0;
        meth_q[s]   <= UPD_CONT;
      end
    end else begin
      st_q     <= st_d;
      ptr_q    <= ptr_d;
      link_q   <= link_d;
      rel_q    <= rel_d;
      len_q    <= len_d;
      addr_q   <= addr_d;
      shadow_q <= shadow_d;
      meth_q   <= meth_d;
    end
  end

  assign unused_desc = ^{desc_w[DW_CLO][DW-1:2], desc_w[DW_CHI][DW-1:LEN_W]};

  // status sources
  always_comb begin
    stat_set            = '0;
    stat_set[STAT_TFR]  = fin;
    stat_set[STAT_BLK]  = blk_end;
    stat_set[STAT_SRCT] = src_xact && chan_en;
    stat_set[STAT_DSTT] = dst_xact && chan_en;
    stat_set[STAT_ERR]  = start_bad || chk_bad;
  end

  dma_stat_bank #(.N(NSTAT)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (stat_set),
    .clr_we  (reg_we && reg_sel == SEL_CLR),
    .mask_we (reg_we && reg_sel == SEL_MASK),
    .wbits   (reg_wdata[NSTAT-1:0]),
    .raw     (raw_stat),
    .masked  (irq_stat),
    .irq     (irq)
  );

  assign chan_en  = !idle;
  assign blk_busy = (st_q == ST_RUN);
  assign blk_src  = addr_q[0];
  assign blk_dst  = addr_q[1];
  assign blk_len  = len_q;

endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          blk_busy,
  input logic          blk_done,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [DW-1:0] rd_addr,
  input logic [4:0]    raw_stat
);

  // R2
  tfr_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_stat[0]) |-> (!chan_en && $past(chan_en)));

  // R8
  en_fall_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_en) |-> (raw_stat[0] || raw_stat[4]));

  // R5
  fetch_outside_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !blk_busy);

  // R5
  fetch_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R9
  blk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_busy && blk_done) |=> raw_stat[1]);

  // R7
  busy_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_busy |-> chan_en);

  // R8
  err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_stat[4]) |-> !blk_busy);

endmodule

bind dma_chain_seq dma_chain_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;

  localparam int DW = 32;
  localparam int LW = 16;

  typedef struct packed {
    logic [DW-1:0] src;
    logic [DW-1:0] dst;
    logic [LW-1:0] len;
  } blk_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [2:0]    reg_sel;
  logic [DW-1:0] reg_wdata;
  logic          start;
  logic          chan_en, blk_busy;
  logic [DW-1:0] blk_src, blk_dst;
  logic [LW-1:0] blk_len;
  logic          blk_done, src_xact, dst_xact;
  logic          rd_req, rd_ack;
  logic [DW-1:0] rd_addr, rd_data;
  logic [4:0]    raw_stat, irq_stat;
  logic          irq;

  int   n_chk = 0;
  int   n_bad = 0;
  blk_t exp_q [$];
  int   blk_seen = 0;
  int   clr_at = 0;
  int   poke_at = 0;
  logic [DW-1:0] mem [0:63];

  always #5 clk = ~clk;

  dma_chain_seq #(.DW(DW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .start(start), .chan_en(chan_en),
    .blk_busy(blk_busy), .blk_src(blk_src), .blk_dst(blk_dst),
    .blk_len(blk_len), .blk_done(blk_done), .src_xact(src_xact),
    .dst_xact(dst_xact), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .raw_stat(raw_stat),
    .irq_stat(irq_stat), .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] sel, input logic [DW-1:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(input logic [DW-1:0] s, input logic [DW-1:0] d,
                       input logic [DW-1:0] p, input logic [DW-1:0] clo,
                       input logic [DW-1:0] len, input logic [DW-1:0] cfg);
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, p);
    wr(3'd3, clo); wr(3'd4, len); wr(3'd5, cfg);
  endtask

  task automatic expect_blk(input logic [DW-1:0] s, input logic [DW-1:0] d,
                            input logic [LW-1:0] l);
    exp_q.push_back('{src: s, dst: d, len: l});
  endtask

  task automatic go();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (chan_en) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic reset_test();
    wr(3'd7, 32'h1f);
    blk_seen = 0; clr_at = 0; poke_at = 0;
  endtask

  // scoreboard monitor: compare each block handed to the mover
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && blk_busy && !prev) begin
        if (exp_q.size() == 0) begin
          check("R6 unexpected block src", blk_src, 32'hffff_ffff);
        end else begin
          blk_t e;
          e = exp_q.pop_front();
          check("R2/R3/R4/R5 block src", blk_src, e.src);
          check("R2/R3/R4/R5 block dst", blk_dst, e.dst);
          check("R2/R3/R4/R5 block len", {16'h0, blk_len}, {16'h0, e.len});
        end
      end
      prev = blk_busy;
    end
  end

  // data mover model with per-test hooks
  initial begin
    int cnt;
    cnt = 0;
    blk_done = 1'b0;
    forever begin
      @(negedge clk);
      if (blk_done) begin
        blk_done = 1'b0;
        cnt = 0;
      end else if (blk_busy) begin
        cnt++;
        if (cnt == 1) begin
          blk_seen++;
          if (blk_seen == clr_at) begin
            wr(3'd5, 32'h0);
            cnt++;
          end
          if (blk_seen == poke_at) begin
            wr(3'd0, 32'h0000_0eee);
            cnt++;
          end
        end
        if (cnt >= 4) blk_done = 1'b1;
      end
    end
  end

  // descriptor memory: one word per request, ack on alternate cycles
  initial begin
    rd_ack = 1'b0;
    rd_data = '0;
    forever begin
      @(negedge clk);
      if (rd_req && !rd_ack) begin
        rd_ack = 1'b1;
        rd_data = mem[rd_addr[7:2]];
      end else begin
        rd_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    // descriptor at 0x40
    mem[16] = 32'h0000_0700; mem[17] = 32'h0000_0800; mem[18] = 32'h0000_0060;
    mem[19] = 32'h0000_0003; mem[20] = 32'h0000_000c;
    // descriptor at 0x60: last block, non-zero pointer
    mem[24] = 32'h0000_0900; mem[25] = 32'h0000_0a00; mem[26] = 32'h0000_0080;
    mem[27] = 32'h0000_0000; mem[28] = 32'h0000_0004;
    // descriptor at 0x80: last block, zero pointer
    mem[32] = 32'h0000_0b00; mem[33] = 32'h0000_0c00; mem[34] = 32'h0000_0000;
    mem[35] = 32'h0000_0000; mem[36] = 32'h0000_0002;

    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    start = 1'b0; src_xact = 1'b0; dst_xact = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 chan_en", {31'h0, chan_en}, 32'h0);
    check("R1 blk_busy", {31'h0, blk_busy}, 32'h0);
    check("R1 rd_req", {31'h0, rd_req}, 32'h0);
    check("R1 raw_stat", {27'h0, raw_stat}, 32'h0);
    check("R1 irq", {26'h0, irq, irq_stat}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: transaction pulses while idle are ignored
    src_xact = 1'b1; dst_xact = 1'b1;
    @(negedge clk);
    src_xact = 1'b0; dst_xact = 1'b0;
    @(negedge clk);
    check("R11 idle xact ignored", {27'h0, raw_stat}, 32'h0);

    // R2: single block
    setup(32'h1000, 32'h2000, 32'h0, 32'h0, 32'h40, 32'h0);
    expect_blk(32'h1000, 32'h2000, 16'h40);
    go();
    @(negedge clk);
    src_xact = 1'b1;
    @(negedge clk);
    src_xact = 1'b0; dst_xact = 1'b1;
    @(negedge clk);
    dst_xact = 1'b0;
    wait_idle();
    check("R2 blocks consumed", exp_q.size(), 0);
    check("R2 R11 raw after single", {27'h0, raw_stat}, 32'h0f);
    check("R10 mask zero", {26'h0, irq, irq_stat}, 32'h0);
    wr(3'd6, 32'h12);
    check("R10 masked status", {27'h0, irq_stat}, 32'h02);
    check("R10 irq", {31'h0, irq}, 32'h1);
    wr(3'd7, 32'h05);
    check("R10 w1c", {27'h0, raw_stat}, 32'h0a);
    reset_test();
    check("R10 clear all", {27'h0, raw_stat}, 32'h0);

    // R3: reload both sides, cleared during third block
    setup(32'h100, 32'h200, 32'h0, 32'h0, 32'h10, 32'h3);
    for (int i = 0; i < 4; i++) expect_blk(32'h100, 32'h200, 16'h10);
    clr_at = 3;
    go();
    wait_idle();
    check("R3 blocks consumed", exp_q.size(), 0);
    check("R3 R9 raw", {27'h0, raw_stat}, 32'h03);
    check("R3 block count", blk_seen, 4);
    reset_test();

    // R4: contiguous source, reloaded destination; R12 source write ignored
    setup(32'h300, 32'h400, 32'h0, 32'h0, 32'h20, 32'h2);
    expect_blk(32'h300, 32'h400, 16'h20);
    expect_blk(32'h320, 32'h400, 16'h20);
    expect_blk(32'h340, 32'h400, 16'h20);
    expect_blk(32'h360, 32'h400, 16'h20);
    clr_at = 3; poke_at = 2;
    go();
    wait_idle();
    check("R4 R12 blocks consumed", exp_q.size(), 0);
    check("R4 raw", {27'h0, raw_stat}, 32'h03);
    reset_test();

    // R5/R6: chain ending with non-zero pointer; R12 repeated start
    setup(32'h500, 32'h600, 32'h41, 32'h3, 32'h8, 32'h0);
    expect_blk(32'h500, 32'h600, 16'h8);
    expect_blk(32'h700, 32'h800, 16'hc);
    expect_blk(32'h900, 32'ha00, 16'h4);
    go();
    @(negedge clk);
    go();
    wait_idle();
    check("R5 R6 R12 blocks consumed", exp_q.size(), 0);
    check("R6 raw", {27'h0, raw_stat}, 32'h03);
    check("R6 block count", blk_seen, 3);
    reset_test();

    // R6: chain ending with zero pointer
    setup(32'h50, 32'h60, 32'h80, 32'h3, 32'h10, 32'h0);
    expect_blk(32'h50, 32'h60, 16'h10);
    expect_blk(32'hb00, 32'hc00, 16'h2);
    go();
    wait_idle();
    check("R6 zero ptr blocks consumed", exp_q.size(), 0);
    check("R6 zero ptr raw", {27'h0, raw_stat}, 32'h03);
    reset_test();

    // R8: source-only link, descriptor turns on both links
    setup(32'h500, 32'h600, 32'h40, 32'h2, 32'h8, 32'h0);
    expect_blk(32'h500, 32'h600, 16'h8);
    go();
    wait_idle();
    repeat (10) @(negedge clk);
    check("R8 blocks consumed", exp_q.size(), 0);
    check("R8 raw error no tfr", {27'h0, raw_stat}, 32'h12);
    check("R8 chan_en", {31'h0, chan_en}, 32'h0);
    reset_test();

    // R7: same-side link and reload at start
    setup(32'h10, 32'h20, 32'h40, 32'h2, 32'h8, 32'h1);
    go();
    check("R7 chan_en", {31'h0, chan_en}, 32'h0);
    repeat (6) @(negedge clk);
    check("R7 raw error", {27'h0, raw_stat}, 32'h10);
    check("R7 no block", blk_seen, 0);
    reset_test();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule